// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Warning

This block is a memory-mapped watchdog for a host processor. Software loads a down-counter whose unit is one coarse tick. A prescaler derives that tick from the system clock, and each tick stands for 128 ms in the full-rate build. Software starts the counter through a control byte and keeps the system alive by rewriting the count before it runs out. Software can read the count at any time to learn how many ticks remain.

When the warning option is set, the block raises a level non-maskable interrupt a fixed number of ticks before expiry. It marks itself as the source in a cause byte, so the interrupt handler can tell this watchdog apart from other sources. When the count reaches zero and reset-on-expiry is enabled, the block drives a system reset pulse of fixed length and holds the count at zero.

Top module: `gtimer`

## Requirements
- R1: After reset with `strap_run` low, the count reads 0xFFFF, control reads 0x00, the cause byte reads 0x00, and `nmi_o` and `sys_rst_o` are low.
- R2: If `strap_run` is high during reset, control reads 0x81 after reset release and the count decrements from 0xFFFF without any software write.
- R3: A write to the count register at byte offset 0x70 reloads the counter. Byte lane 0 (`bus_be[0]`) carries bits 7:0 and lane 1 carries bits 15:8. A lane that is not strobed keeps the current count bits.
- R4: While control bit 0 is set, the count drops by exactly one every TICK_DIV clock cycles. The first decrement comes TICK_DIV cycles after the edge that reloads the count or sets bit 0.
- R5: A read of offset 0x70 returns the ticks still remaining, and the count never wraps below zero.
- R6: Clearing control bit 0 freezes the count. Every control bit (0 run, 2 warning enable, 7 reset enable, and the others) reads back exactly as last written through byte lane 0 of offset 0x72.
- R7: With control bits 0 and 2 set, the tick that takes the count from PRE_LEAD+1 to PRE_LEAD sets cause bits 1 and 2, so the cause byte at offset 0x6E reads 0x06. On that same edge `nmi_o` goes high and stays high as a level.
- R8: A count loaded at or below PRE_LEAD never crosses the threshold, so it raises no warning even when it runs to zero.
- R9: Writing 1s to cause bits 1 and 2 through lane 0 of offset 0x6E clears them and drops `nmi_o`. Writing 0s changes nothing.
- R10: A count write (kick) clears a pending cause and drops `nmi_o` on the same edge.
- R11: With control bits 0 and 7 set, the tick that takes the count from 1 to 0 starts a `sys_rst_o` pulse lasting exactly RST_CYCLES cycles. The count then holds at zero.
- R12: With control bit 7 clear, the count reaches zero and holds there, and no reset pulse is produced.
- R13: Offsets other than 0x6E, 0x70 and 0x72 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_run | input | 1 | Sampled during reset: start the timer running out of reset |
| bus_addr | input | 7 | Byte address within the 128-byte window |
| bus_wr | input | 1 | Write enable |
| bus_be | input | 2 | Byte-lane strobes (lane 0 = even byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| nmi_o | output | 1 | Level warning interrupt |
| sys_rst_o | output | 1 | System reset pulse on expiry |

## Verification
On every cycle, the assertions check several local properties. The count moves only on a reload or a tick, it steps by exactly one, and it holds at zero. A kick or a write-one-clear removes the warning. The warning can only rise while warning enable is set. The reset pulse starts only from an enabled expiry at zero. The bench scenarios show the rest: the exact tick spacing and the cycle on which the warning and the reset pulse appear, the full pulse length, lane merging on partial writes, control readback after a read-modify-write stop, and the start-running strap.

// File: rtl/gtimer_pkg.sv
package gtimer_pkg;

   localparam logic [6:0] OFS_CAUSE = 7'h6E;
   localparam logic [6:0] OFS_COUNT = 7'h70;
   localparam logic [6:0] OFS_CTRL  = 7'h72;

   localparam int CTL_RUN   = 0;
   localparam int CTL_WARN  = 2;
   localparam int CTL_RSTEN = 7;

   localparam logic [7:0] CAUSE_BITS = 8'h06;
   localparam logic [7:0] CTRL_BOOT  = 8'h81;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CAUSE,
      SEL_COUNT,
      SEL_CTRL
   } reg_sel_e;

   function automatic reg_sel_e decode_sel(input logic [6:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == OFS_CAUSE)      s = SEL_CAUSE;
      else if (a == OFS_COUNT) s = SEL_COUNT;
      else if (a == OFS_CTRL)  s = SEL_CTRL;
      return s;
   endfunction

endpackage

// File: rtl/gtimer_prescale.sv
module gtimer_prescale #(
   parameter int unsigned TICK_DIV = 6400000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end

      if (TICK_DIV == 1) begin : g_direct
         assign tick = run && !restart;
      end else begin : g_divider
         logic [DIV_W-1:0] div_q;
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (!run || restart)  div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end

         assign tick = run && !restart && (div_q == DIV_LAST);

         AST_DIV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> div_q == '0) else $error("divider moved while stopped"); // R4
      end
   endgenerate

endmodule

// File: rtl/gtimer_count.sv
module gtimer_count #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned PRE_LEAD = 70
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             cross_pre,
   output logic             expire
);
   localparam logic [CNT_W-1:0] CROSS_AT = CNT_W'(PRE_LEAD + 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   generate
      if (PRE_LEAD < 1 || PRE_LEAD + 2 > (2 ** CNT_W) - 1) begin : g_bad_lead
         $error("PRE_LEAD out of range for CNT_W");
      end
   endgenerate

   logic step;
   assign step = tick && !load && (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '1;
      else if (load) count <= load_val;
      else if (step) count <= count - 1'b1;
   end

   assign cross_pre = step && (count == CROSS_AT);
   assign expire    = step && (count == ONE);

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(load_val)) else $error("reload lost"); // R3
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count != '0) |=> count == $past(count) - 1'b1) else $error("bad step"); // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count)) else $error("count drifted"); // R6
   AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load) |=> count == '0) else $error("count wrapped"); // R12

endmodule

// File: rtl/gtimer_rstpulse.sv
module gtimer_rstpulse #(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   localparam int unsigned RW = $clog2(RST_CYCLES + 1);

   generate
      if (RST_CYCLES < 1) begin : g_bad_len
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   logic [RW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (fire)           left_q <= RW'(RST_CYCLES);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign pulse = (left_q != '0);

   AST_FIRE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> pulse) else $error("expiry without pulse"); // R11
   AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pulse && !fire) |=> !pulse) else $error("spurious pulse"); // R12

endmodule

// File: rtl/gtimer.sv
module gtimer #(
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned TICK_DIV   = 6400000,
   parameter int unsigned PRE_LEAD   = 70,
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_run,
   input  logic [6:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [1:0]        bus_be,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              nmi_o,
   output logic              sys_rst_o
);
   import gtimer_pkg::*;

   localparam int unsigned NB = DATA_W / 8;

   generate
      if (DATA_W != 16) begin : g_bad_w
         $error("bus and count width must be 16");
      end
   endgenerate

   reg_sel_e          sel;
   logic [7:0]        ctrl_q;
   logic [7:0]        cause_q;
   logic [DATA_W-1:0] count;
   logic [DATA_W-1:0] load_val;
   logic              kick;
   logic              ctrl_wr;
   logic              cause_w1c;
   logic              tick;
   logic              cross_pre;
   logic              expire;
   logic              warn_set;

   assign sel       = decode_sel(bus_addr);
   assign kick      = bus_wr && (sel == SEL_COUNT) && (|bus_be);
   assign ctrl_wr   = bus_wr && (sel == SEL_CTRL)  && bus_be[0];
   assign cause_w1c = bus_wr && (sel == SEL_CAUSE) && bus_be[0];

   // lane merge for partial reloads
   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign load_val[8*b +: 8] = bus_be[b] ? bus_wdata[8*b +: 8] : count[8*b +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= strap_run ? CTRL_BOOT : 8'h00;
      else if (ctrl_wr) ctrl_q <= bus_wdata[7:0];
   end

   gtimer_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl_q[CTL_RUN]),
      .restart(kick),
      .tick   (tick)
   );

   gtimer_count #(.CNT_W(DATA_W), .PRE_LEAD(PRE_LEAD)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (kick),
      .load_val (load_val),
      .tick     (tick),
      .count    (count),
      .cross_pre(cross_pre),
      .expire   (expire)
   );

   assign warn_set = cross_pre && ctrl_q[CTL_WARN];

   // set beats write-one-clear; a kick clears outright
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cause_q <= 8'h00;
      else if (kick)      cause_q <= 8'h00;
      else if (warn_set)  cause_q <= cause_q | CAUSE_BITS;
      else if (cause_w1c) cause_q <= cause_q & ~(bus_wdata[7:0] & CAUSE_BITS);
   end

   assign nmi_o = |(cause_q & CAUSE_BITS);

   gtimer_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (expire && ctrl_q[CTL_RSTEN]),
      .pulse(sys_rst_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_CAUSE: bus_rdata[7:0] = cause_q;
         SEL_COUNT: bus_rdata      = count;
         SEL_CTRL:  bus_rdata[7:0] = ctrl_q;
         default:   bus_rdata      = '0;
      endcase
   end

   AST_NMI_ONSET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_o) |-> $past(ctrl_q[CTL_WARN]) && $past(ctrl_q[CTL_RUN])) else $error("warning without enable"); // R7
   AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !nmi_o) else $error("kick left warning"); // R10
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_w1c && bus_wdata[2:1] == 2'b11 && !cross_pre) |=> !nmi_o) else $error("clear ignored"); // R9
   AST_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(ctrl_q[CTL_RSTEN]) && count == '0) else $error("reset without expiry"); // R11
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl_q)) else $error("control changed"); // R6

endmodule

// File: tb/gtimer_bench.sv
module gtimer_bench;
   localparam int D   = 4;
   localparam int PRE = 6;
   localparam int RC  = 5;
   localparam logic [6:0] A_CAUSE = 7'h6E, A_COUNT = 7'h70, A_CTRL = 7'h72, A_NONE = 7'h74;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_run = 1'b0;
   logic [6:0]  b_addr = '0;
   logic        b_wr = 1'b0;
   logic [1:0]  b_be = '0;
   logic [15:0] b_wdata = '0;
   logic [15:0] b_rdata;
   logic        nmi, srst;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   gtimer #(.DATA_W(16), .TICK_DIV(D), .PRE_LEAD(PRE), .RST_CYCLES(RC)) u_gtimer (
      .clk(clk), .rst_n(rst_n), .strap_run(strap_run),
      .bus_addr(b_addr), .bus_wr(b_wr), .bus_be(b_be), .bus_wdata(b_wdata),
      .bus_rdata(b_rdata), .nmi_o(nmi), .sys_rst_o(srst)
   );

   function automatic int exp_cnt(input int n, input int k);
      return (n > k) ? n - k : 0;
   endfunction

   function automatic bit exp_warn(input int n, input int k, input bit pre);
      return pre && (n > PRE) && (exp_cnt(n, k) <= PRE);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [15:0] d, input logic [1:0] be);
      @(negedge clk);
      b_addr = a; b_wdata = d; b_be = be; b_wr = 1'b1;
      @(negedge clk);
      b_wr = 1'b0; b_be = '0;
   endtask

   task automatic rd(input logic [6:0] a, output int v);
      b_addr = a;
      #1;
      v = int'(b_rdata);
   endtask

   task automatic wait_cyc(input int m);
      repeat (m) @(negedge clk);
   endtask

   task automatic arm(input int n, input logic [7:0] ctl);
      wr(A_CTRL, 16'h0000, 2'b01);
      wr(A_CAUSE, 16'h0006, 2'b01);
      wr(A_COUNT, 16'(n), 2'b11);
      wr(A_CTRL, {8'h00, ctl}, 2'b01);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int v;
      void'($urandom(32'h5EED));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      rd(A_COUNT, v); chk("R1 count", v, 16'hFFFF);
      rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
      rd(A_CAUSE, v); chk("R1 cause", v, 0);
      chk("R1 nmi", int'(nmi), 0);
      chk("R1 rst", int'(srst), 0);

      // R3 full and partial reload, timer stopped
      wr(A_COUNT, 16'h1234, 2'b11);
      rd(A_COUNT, v); chk("R3 full load", v, 16'h1234);
      wr(A_COUNT, 16'hAB00, 2'b10);
      rd(A_COUNT, v); chk("R3 lane1 merge", v, 16'hAB34);
      wr(A_COUNT, 16'h00CD, 2'b01);
      rd(A_COUNT, v); chk("R3 lane0 merge", v, 16'hABCD);

      // R13 unmapped offset
      wr(A_NONE, 16'hFFFF, 2'b11);
      rd(A_NONE, v);  chk("R13 unmapped read", v, 0);
      rd(A_COUNT, v); chk("R13 count kept", v, 16'hABCD);
      rd(A_CTRL, v);  chk("R13 ctrl kept", v, 0);

      // R4 tick spacing
      arm(20, 8'h01);
      wait_cyc(D - 1);
      rd(A_COUNT, v); chk("R4 before first tick", v, 20);
      wait_cyc(1);
      rd(A_COUNT, v); chk("R4 first tick", v, 19);
      wait_cyc(3 * D);
      rd(A_COUNT, v); chk("R4 later ticks", v, 16);

      // R6 read-modify-write stop
      wr(A_CTRL, 16'h0085, 2'b01);
      rd(A_CTRL, v);
      wr(A_CTRL, 16'(v & 8'hFE), 2'b01);
      rd(A_CTRL, v); chk("R6 ctrl after stop", v, 8'h84);
      begin
         int c0;
         rd(A_COUNT, c0);
         wait_cyc(5 * D);
         rd(A_COUNT, v); chk("R6 count frozen", v, c0);
      end

      // R7 pretimeout crossing
      arm(10, 8'h85);
      wait_cyc((10 - PRE) * D - 1);
      chk("R7 nmi before lead", int'(nmi), 0);
      wait_cyc(1);
      chk("R7 nmi at lead", int'(nmi), 1);
      rd(A_CAUSE, v); chk("R7 cause byte", v, 8'h06);

      // R9 write-one-clear
      wr(A_CAUSE, 16'h0000, 2'b01);
      chk("R9 zeros keep nmi", int'(nmi), 1);
      wr(A_CAUSE, 16'h0006, 2'b01);
      chk("R9 clear nmi", int'(nmi), 0);
      rd(A_CAUSE, v); chk("R9 cause cleared", v, 0);

      // R10 kick clears pending warning
      arm(8, 8'h85);
      wait_cyc((8 - PRE) * D);
      chk("R10 warning up", int'(nmi), 1);
      wr(A_COUNT, 16'd30, 2'b11);
      chk("R10 kick clears nmi", int'(nmi), 0);
      rd(A_CAUSE, v); chk("R10 cause cleared", v, 0);
      rd(A_COUNT, v); chk("R5 reload readback", v, 30);

      // R8 and R12: load below lead, no reset enable
      arm(PRE - 1, 8'h05);
      wait_cyc((PRE + 2) * D);
      chk("R8 no warning", int'(nmi), 0);
      rd(A_COUNT, v); chk("R12 count holds zero", v, 0);
      chk("R12 no reset pulse", int'(srst), 0);

      // R11 expiry with reset enable
      arm(3, 8'h81);
      wait_cyc(3 * D - 1);
      chk("R11 before expiry", int'(srst), 0);
      rd(A_COUNT, v); chk("R11 count one", v, 1);
      wait_cyc(1);
      chk("R11 pulse starts", int'(srst), 1);
      rd(A_COUNT, v); chk("R11 count zero", v, 0);
      wait_cyc(RC - 1);
      chk("R11 pulse last", int'(srst), 1);
      wait_cyc(1);
      chk("R11 pulse ends", int'(srst), 0);
      wait_cyc(2 * D);
      rd(A_COUNT, v); chk("R11 holds zero", v, 0);

      // R5 R7 random reload and wait
      for (int i = 0; i < 12; i++) begin
         int n, k;
         bit pre;
         n   = 8 + int'($urandom % 30);
         k   = int'($urandom % (n + 3));
         pre = 1'($urandom % 2);
         arm(n, pre ? 8'h05 : 8'h01);
         wait_cyc(k * D);
         rd(A_COUNT, v); chk("R5 random remaining", v, exp_cnt(n, k));
         chk("R7 random warning", int'(nmi), int'(exp_warn(n, k, pre)));
      end

      // R2 start-running strap
      @(negedge clk);
      rst_n = 1'b0; strap_run = 1'b1;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(2 * D);
      rd(A_CTRL, v);  chk("R2 ctrl boot", v, 8'h81);
      rd(A_COUNT, v); chk("R2 count running", v, 16'hFFFD);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule